// File: doc/BRIEF.md
# Root Port Status and Control

This block keeps the status and control word of one downstream port on the root hub of a USB 2.0 host controller. It watches the PHY-side connect, line-state, J-to-K and high-speed-detect signals and an over-current input, and it runs the port through power-off, disabled, bus reset, enabled, suspended and resume. Software drives the port through a single full-word write port and reads back one 32-bit status word. The block sets sticky change flags when connect state, enable state or over-current state changes, and pulses a change-detect output for each new change while this controller owns the port.

Ownership follows the controller-wide configure flag. When a connected and disabled port reports a K line state (a low-speed device), the port hands itself to the companion controller. The bus-reset and resume-exit waits are timed in millisecond ticks.

The port state machine `rport_fsm` has eight states:

- **OFF**: port power is 0. Every state goes to OFF as soon as power is 0. OFF goes to DIS once power is 1.
- **DIS**: powered and disabled.
  - DIS goes to RST on a write with bit 8 = 1 while connected.
- **RST**: bus reset is being driven.
  - RST goes to RST_END on a write with bit 8 = 0.
- **RST_END**: the settle wait after reset.
  - After `SETTLE_TICKS` ticks it goes to EN if `phy_hs` is high at the last tick, and to DIS otherwise.
- **EN**: enabled.
  - EN goes to RST on a write with bit 8 = 1.
  - EN goes to DIS on a write with bit 2 = 0.
  - EN goes to SUSP on a write with bit 7 = 1.
- **SUSP**: suspended.
  - SUSP goes to RESUME on a J-to-K pulse; this is a hardware resume.
  - SUSP goes to RESUME on a write with bit 6 = 1; this is a software resume.
  - SUSP goes to DIS on a write with bit 2 = 0.
- **RESUME**: resume signalling is being driven.
  - RESUME goes to RES_END on a write with bit 6 = 0.
  - RESUME goes to DIS on a write with bit 2 = 0.
- **RES_END**: the settle wait after resume.
  - After `SETTLE_TICKS` ticks it goes to EN.
- **Disconnect**: a disconnect in any powered state leads to DIS. If the port was enabled, this is a hardware disable.

Top module: `rport_ctrl`

## Requirements
- R1: After reset, with the configure flag low, `port_reg` reads 32'h0000_2000: only the owner bit is set. `chg_det` is 0.
- R2: Owner bit 13 reads 1 while `cfg_flag` is 0. It becomes 0 on the clock after `cfg_flag` rises. Otherwise it takes the written bit 13.
- R3: Connect bit 0 shows `phy_conn` gated by power, one clock after the input. Connect-change bit 1 is set on every change of bit 0, even when it is already set, and is cleared by writing 1. A new change in the same clock as the clearing write wins.
- R4: Writing 1 to enable bit 2 never enables the port. Writing 0 to bit 2 disables an enabled port and does not set bit 3.
- R5: A write with reset bit 8 = 1 starts bus reset on a connected port. After a write with bit 8 = 0, bit 8 keeps reading 1 until `SETTLE_TICKS` ms ticks have passed. The port then reads enabled only if `phy_hs` was high at that tick.
- R6: Writing 1 to suspend bit 7 on an enabled port makes bits 2 and 7 both read 1.
- R7: In suspend, a J-to-K pulse sets force-resume bit 6 and pulses `chg_det`. A software write of 1 to bit 6 sets it without a pulse. After bit 6 is written 0, it keeps reading 1 until `SETTLE_TICKS` ticks have passed. The port then reads enabled, with bits 6 and 7 clear.
- R8: A disconnect on an enabled port clears bit 2 and sets enable-change bit 3. Bit 3 is cleared by writing 1.
- R9: Over-current-active bit 4 follows `oc_in` one clock later. Over-current-change bit 5 is set on every change of bit 4 and cleared by writing 1. Neither bit is gated by power.
- R10: Line bits [11:10] show {D+, D-} from `phy_line[1:0]` one clock later, and read 0 while power is off.
- R11: With `AUTO_HANDOFF` = 1, a connected, disabled port owned by this controller whose line bits read 01 (K) sets owner bit 13 on the next clock. Codes 00, 10 and 11 leave ownership alone.
- R12: Power bit 12 is written directly. While it is 0, bits 0, 1, 2, 3, 6, 7, 8, 10 and 11 read 0.
- R13: Test-mode field [19:16] stores written codes 0 to `TEST_MAX` (default 5: off, J, K, SE0_NAK, packet, force-enable). Codes above that leave it unchanged.
- R14: `chg_det` is a one-clock pulse when bit 1, 3 or 5 goes from 0 to 1, or when a hardware resume starts. It pulses only while owner bit 13 is 0 and power is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| phy_conn | input | 1 | Device attached |
| phy_line | input | 2 | Line state, bit 1 = D+, bit 0 = D- |
| phy_jk | input | 1 | J-to-K transition pulse |
| phy_hs | input | 1 | High-speed device found during reset |
| oc_in | input | 1 | Over-current condition |
| cfg_flag | input | 1 | Controller-wide configure flag |
| ms_tick | input | 1 | One-clock pulse each millisecond |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| port_reg | output | 32 | Port status and control word |
| chg_det | output | 1 | Port change detect pulse |

## Verification
The state machine is exercised along several paths:

- **Reset outcomes.** Reset is ended once with `phy_hs` high and once with it low. This separates the enable decision from the mere end of reset.
- **Two resume sources.** Resume is entered once by a J-to-K pulse and once by a software write. Only the first may pulse `chg_det`.
- **Change flags.** Connect and over-current changes are raised both while the flag is clear and while it is already set. This separates edge-raised `chg_det` from level-held sticky bits. A change arriving in the same clock as a clearing write checks the set-wins rule.
- **Ownership.** Line codes J and K are applied to a disabled port to tell auto-handoff apart from plain reporting. Changes made while the companion owns the port must not pulse `chg_det`.

// File: rtl/rport_pkg.sv
package rport_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_DIS,
        ST_RST,
        ST_RST_END,
        ST_EN,
        ST_SUSP,
        ST_RESUME,
        ST_RES_END
    } port_st_t;

    // Field positions of the port word (software decodes these)
    localparam int unsigned B_CCS   = 0;
    localparam int unsigned B_CSC   = 1;
    localparam int unsigned B_PE    = 2;
    localparam int unsigned B_PEC   = 3;
    localparam int unsigned B_OCA   = 4;
    localparam int unsigned B_OCC   = 5;
    localparam int unsigned B_FPR   = 6;
    localparam int unsigned B_SUSP  = 7;
    localparam int unsigned B_PRST  = 8;
    localparam int unsigned B_LINE  = 10;
    localparam int unsigned B_PWR   = 12;
    localparam int unsigned B_OWN   = 13;
    localparam int unsigned B_TEST  = 16;
    localparam int unsigned TEST_W  = 4;

    typedef struct packed {
        logic pe;
        logic susp;
        logic fpr;
        logic prst;
    } fsm_wr_t;

    typedef struct packed {
        logic              csc_clr;
        logic              pec_clr;
        logic              occ_clr;
        logic              pwr;
        logic              own;
        logic [TEST_W-1:0] test;
    } flg_wr_t;

endpackage

// File: rtl/rport_fsm.sv
module rport_fsm
    import rport_pkg::*;
#(
    parameter int unsigned SETTLE_TICKS = 1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pwr,
    input  logic     phy_conn,
    input  logic     phy_jk,
    input  logic     phy_hs,
    input  logic     ms_tick,
    input  logic     wr_en,
    input  fsm_wr_t  wr,
    output port_st_t st,
    output logic     pe,
    output logic     susp,
    output logic     fpr,
    output logic     prst,
    output logic     hw_dis,
    output logic     jk_res
);

    localparam int unsigned CW = $clog2(SETTLE_TICKS + 1);

    port_st_t       st_q, st_n;
    logic [CW-1:0]  cnt_q;
    logic           conn, settling, done;

    assign conn     = phy_conn & pwr;
    assign settling = (st_q == ST_RST_END) || (st_q == ST_RES_END);
    assign done     = ms_tick && (cnt_q == CW'(SETTLE_TICKS - 1));

    always_comb begin
        st_n   = st_q;
        hw_dis = 1'b0;
        jk_res = 1'b0;
        if (!pwr) begin
            st_n = ST_OFF;
        end else begin
            unique case (st_q)
                ST_OFF: st_n = ST_DIS;
                ST_DIS: begin
                    if (wr_en && wr.prst && conn) st_n = ST_RST;
                end
                ST_RST: begin
                    if (!conn)                    st_n = ST_DIS;
                    else if (wr_en && !wr.prst)   st_n = ST_RST_END;
                end
                ST_RST_END: begin
                    if (!conn)                    st_n = ST_DIS;
                    else if (done)                st_n = phy_hs ? ST_EN : ST_DIS;
                end
                ST_EN: begin
                    if (!conn) begin
                        st_n   = ST_DIS;
                        hw_dis = 1'b1;
                    end else if (wr_en && wr.prst) st_n = ST_RST;
                    else if (wr_en && !wr.pe)      st_n = ST_DIS;
                    else if (wr_en && wr.susp)     st_n = ST_SUSP;
                end
                ST_SUSP: begin
                    if (!conn) begin
                        st_n   = ST_DIS;
                        hw_dis = 1'b1;
                    end else if (wr_en && !wr.pe)  st_n = ST_DIS;
                    else if (phy_jk) begin
                        st_n   = ST_RESUME;
                        jk_res = 1'b1;
                    end else if (wr_en && wr.fpr)  st_n = ST_RESUME;
                end
                ST_RESUME: begin
                    if (!conn) begin
                        st_n   = ST_DIS;
                        hw_dis = 1'b1;
                    end else if (wr_en && !wr.pe)  st_n = ST_DIS;
                    else if (wr_en && !wr.fpr)     st_n = ST_RES_END;
                end
                ST_RES_END: begin
                    if (!conn) begin
                        st_n   = ST_DIS;
                        hw_dis = 1'b1;
                    end else if (done)             st_n = ST_EN;
                end
                default: st_n = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_OFF;
            cnt_q <= '0;
        end else begin
            st_q <= st_n;
            if (settling && ms_tick && !done) cnt_q <= cnt_q + 1'b1;
            else if (!settling || done)       cnt_q <= '0;
        end
    end

    always_comb begin
        pe   = 1'b0;
        susp = 1'b0;
        fpr  = 1'b0;
        prst = 1'b0;
        unique case (st_q)
            ST_OFF, ST_DIS: ;
            ST_RST, ST_RST_END: prst = 1'b1;
            ST_EN: pe = 1'b1;
            ST_SUSP: begin
                pe   = 1'b1;
                susp = 1'b1;
            end
            ST_RESUME, ST_RES_END: begin
                pe   = 1'b1;
                susp = 1'b1;
                fpr  = 1'b1;
            end
            default: ;
        endcase
    end

    assign st = st_q;

    // R4: a disabled port never reads enabled on the next clock
    p_no_sw_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DIS && !(wr_en && wr.prst)) |=> !pe);

    // R5: reset bit holds through the settle wait
    p_rst_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RST_END && !ms_tick && conn) |=> prst);

    // R7: force-resume holds through the resume exit wait
    p_fpr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RES_END && !ms_tick && conn) |=> fpr);

    // R7: a J-to-K pulse in suspend leads to resume signalling
    p_jk_resume_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SUSP && phy_jk && conn && !(wr_en && !wr.pe)) |=> fpr);

endmodule

// File: rtl/rport_flags.sv
module rport_flags
    import rport_pkg::*;
#(
    parameter int unsigned TEST_MAX     = 5,
    parameter bit          AUTO_HANDOFF = 1'b1,
    parameter bit          PWR_RST      = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phy_conn,
    input  logic [1:0]        phy_line,
    input  logic              oc_in,
    input  logic              cfg_flag,
    input  logic              wr_en,
    input  flg_wr_t           wr,
    input  logic              st_dis,
    input  logic              hw_dis,
    input  logic              jk_res,
    output logic              pwr_q,
    output logic              ccs_q,
    output logic              csc_q,
    output logic              pec_q,
    output logic              oca_q,
    output logic              occ_q,
    output logic [1:0]        line_q,
    output logic              owner_q,
    output logic [TEST_W-1:0] test_q,
    output logic              chg_q
);

    logic cfg_q;
    logic conn_now, csc_set, occ_set, release_k, chg_n;

    assign conn_now = phy_conn & pwr_q;
    assign csc_set  = pwr_q & (conn_now != ccs_q);
    assign occ_set  = (oc_in != oca_q);

    generate
        if (AUTO_HANDOFF) begin : g_auto
            assign release_k = st_dis && ccs_q && (line_q == 2'b01) && !owner_q;
        end else begin : g_manual
            assign release_k = 1'b0;
        end
    endgenerate

    assign chg_n = !owner_q && pwr_q &&
                   ((csc_set && !csc_q) || (hw_dis && !pec_q) ||
                    (occ_set && !occ_q) || jk_res);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr_q   <= PWR_RST;
            ccs_q   <= 1'b0;
            csc_q   <= 1'b0;
            pec_q   <= 1'b0;
            oca_q   <= 1'b0;
            occ_q   <= 1'b0;
            line_q  <= 2'b00;
            owner_q <= 1'b1;
            cfg_q   <= 1'b0;
            test_q  <= '0;
            chg_q   <= 1'b0;
        end else begin
            cfg_q  <= cfg_flag;
            ccs_q  <= conn_now;
            line_q <= phy_line;
            oca_q  <= oc_in;
            chg_q  <= chg_n;

            if (wr_en) pwr_q <= wr.pwr;

            if (!pwr_q)                     csc_q <= 1'b0;
            else if (csc_set)               csc_q <= 1'b1;
            else if (wr_en && wr.csc_clr)   csc_q <= 1'b0;

            if (!pwr_q)                     pec_q <= 1'b0;
            else if (hw_dis)                pec_q <= 1'b1;
            else if (wr_en && wr.pec_clr)   pec_q <= 1'b0;

            if (occ_set)                    occ_q <= 1'b1;
            else if (wr_en && wr.occ_clr)   occ_q <= 1'b0;

            if (!cfg_flag)                  owner_q <= 1'b1;
            else if (!cfg_q)                owner_q <= 1'b0;
            else if (release_k)             owner_q <= 1'b1;
            else if (wr_en)                 owner_q <= wr.own;

            if (wr_en && (wr.test <= TEST_W'(TEST_MAX))) test_q <= wr.test;
        end
    end

    // R2: companion owns the port while the configure flag is low
    p_owner_cfg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_flag |=> owner_q);

    // R3: connect-change stays set without a write
    p_csc_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (csc_q && !wr_en && pwr_q) |=> csc_q);

    // R9: any over-current edge raises the change bit
    p_occ_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_in != oca_q) |=> occ_q);

    // R14: no change pulse while the companion owns the port
    p_no_chg_owned_r14: assert property (@(posedge clk) disable iff (!rst_n)
        owner_q |=> !chg_q);

endmodule

// File: rtl/rport_ctrl.sv
module rport_ctrl
    import rport_pkg::*;
#(
    parameter int unsigned SETTLE_TICKS = 1,
    parameter int unsigned TEST_MAX     = 5,
    parameter bit          AUTO_HANDOFF = 1'b1,
    parameter bit          PWR_RST      = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        phy_conn,
    input  logic [1:0]  phy_line,
    input  logic        phy_jk,
    input  logic        phy_hs,
    input  logic        oc_in,
    input  logic        cfg_flag,
    input  logic        ms_tick,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] port_reg,
    output logic        chg_det
);

    fsm_wr_t           fwr;
    flg_wr_t           gwr;
    port_st_t          st;
    logic              pe, susp, fpr, prst, hw_dis, jk_res;
    logic              pwr, ccs, csc, pec, oca, occ, owner;
    logic [1:0]        line;
    logic [TEST_W-1:0] test;
    logic              unused_wr;

    assign fwr.pe   = wr_data[B_PE];
    assign fwr.susp = wr_data[B_SUSP];
    assign fwr.fpr  = wr_data[B_FPR];
    assign fwr.prst = wr_data[B_PRST];

    assign gwr.csc_clr = wr_data[B_CSC];
    assign gwr.pec_clr = wr_data[B_PEC];
    assign gwr.occ_clr = wr_data[B_OCC];
    assign gwr.pwr     = wr_data[B_PWR];
    assign gwr.own     = wr_data[B_OWN];
    assign gwr.test    = wr_data[B_TEST +: TEST_W];

    assign unused_wr = ^{wr_data[31:20], wr_data[15:14], wr_data[11:9],
                         wr_data[B_OCA], wr_data[B_CCS]};

    rport_fsm #(
        .SETTLE_TICKS(SETTLE_TICKS)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr      (pwr),
        .phy_conn (phy_conn),
        .phy_jk   (phy_jk),
        .phy_hs   (phy_hs),
        .ms_tick  (ms_tick),
        .wr_en    (wr_en),
        .wr       (fwr),
        .st       (st),
        .pe       (pe),
        .susp     (susp),
        .fpr      (fpr),
        .prst     (prst),
        .hw_dis   (hw_dis),
        .jk_res   (jk_res)
    );

    rport_flags #(
        .TEST_MAX     (TEST_MAX),
        .AUTO_HANDOFF (AUTO_HANDOFF),
        .PWR_RST      (PWR_RST)
    ) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .phy_conn (phy_conn),
        .phy_line (phy_line),
        .oc_in    (oc_in),
        .cfg_flag (cfg_flag),
        .wr_en    (wr_en),
        .wr       (gwr),
        .st_dis   (st == ST_DIS),
        .hw_dis   (hw_dis),
        .jk_res   (jk_res),
        .pwr_q    (pwr),
        .ccs_q    (ccs),
        .csc_q    (csc),
        .pec_q    (pec),
        .oca_q    (oca),
        .occ_q    (occ),
        .line_q   (line),
        .owner_q  (owner),
        .test_q   (test),
        .chg_q    (chg_det)
    );

    always_comb begin
        port_reg                      = '0;
        port_reg[B_CCS]               = ccs  & pwr;
        port_reg[B_CSC]               = csc  & pwr;
        port_reg[B_PE]                = pe   & pwr;
        port_reg[B_PEC]               = pec  & pwr;
        port_reg[B_OCA]               = oca;
        port_reg[B_OCC]               = occ;
        port_reg[B_FPR]               = fpr  & pwr;
        port_reg[B_SUSP]              = susp & pwr;
        port_reg[B_PRST]              = prst & pwr;
        port_reg[B_LINE +: 2]         = line & {2{pwr}};
        port_reg[B_PWR]               = pwr;
        port_reg[B_OWN]               = owner;
        port_reg[B_TEST +: TEST_W]    = test;
    end

    // R12: nothing but over-current, power, owner and test reads while unpowered
    p_unpowered_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !port_reg[B_PWR] |-> ((port_reg & 32'h0000_0DCF) == 32'h0));

endmodule

// File: tb/sim_rport_ctrl.sv
module sim_rport_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phy_conn = 1'b0;
    logic [1:0]  phy_line = 2'b00;
    logic        phy_jk = 1'b0;
    logic        phy_hs = 1'b0;
    logic        oc_in = 1'b0;
    logic        cfg_flag = 1'b0;
    logic        ms_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = 32'h0;
    logic [31:0] port_reg;
    logic        chg_det;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    rport_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .phy_conn(phy_conn), .phy_line(phy_line),
        .phy_jk(phy_jk), .phy_hs(phy_hs), .oc_in(oc_in), .cfg_flag(cfg_flag),
        .ms_tick(ms_tick), .wr_en(wr_en), .wr_data(wr_data),
        .port_reg(port_reg), .chg_det(chg_det)
    );

    typedef struct packed {
        logic        wr;
        logic [31:0] wd;
        logic        conn;
        logic [1:0]  line;
        logic        oc;
        logic        jk;
        logic        hs;
        logic        tick;
        logic [31:0] exp;
        logic        chg;
        logic [3:0]  req;
    } row_t;

    localparam int NROW = 39;
    localparam row_t TBL [0:NROW-1] = '{
        '{1'b1, 32'h1000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1000, 1'b0, 4'd12}, // R12 power on
        '{1'b0, 32'h0,    1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1803, 1'b1, 4'd3},  // R3 connect
        '{1'b0, 32'h0,    1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1803, 1'b0, 4'd14}, // R14 one-clock pulse
        '{1'b1, 32'h1002, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1801, 1'b0, 4'd3},  // R3 W1C
        '{1'b1, 32'h1004, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1801, 1'b0, 4'd4},  // R4 enable ignored
        '{1'b1, 32'h1100, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1901, 1'b0, 4'd5},  // R5 start reset
        '{1'b0, 32'h0,    1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 32'h1901, 1'b0, 4'd5},
        '{1'b1, 32'h1000, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1901, 1'b0, 4'd5},  // R5 end requested
        '{1'b0, 32'h0,    1'b1, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 32'h1901, 1'b0, 4'd5},
        '{1'b0, 32'h0,    1'b1, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 32'h1805, 1'b0, 4'd5},  // R5 HS enable
        '{1'b1, 32'h1004, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1805, 1'b0, 4'd4},
        '{1'b1, 32'h1084, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1885, 1'b0, 4'd6},  // R6 suspend
        '{1'b0, 32'h0,    1'b1, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 32'h18C5, 1'b1, 4'd7},  // R7 J-to-K
        '{1'b1, 32'h1084, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h18C5, 1'b0, 4'd7},  // R7 held
        '{1'b0, 32'h0,    1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 32'h1805, 1'b0, 4'd7},
        '{1'b1, 32'h1084, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1885, 1'b0, 4'd6},
        '{1'b1, 32'h10C4, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h18C5, 1'b0, 4'd7},  // R7 sw resume
        '{1'b1, 32'h1084, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h18C5, 1'b0, 4'd7},
        '{1'b0, 32'h0,    1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 32'h1805, 1'b0, 4'd7},
        '{1'b0, 32'h0,    1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 32'h1835, 1'b1, 4'd9},  // R9 oc on
        '{1'b0, 32'h0,    1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1825, 1'b0, 4'd9},  // R9 oc off
        '{1'b1, 32'h1024, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1805, 1'b0, 4'd9},
        '{1'b0, 32'h0,    1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h100A, 1'b1, 4'd8},  // R8 disconnect
        '{1'b1, 32'h100A, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1000, 1'b0, 4'd8},
        '{1'b0, 32'h0,    1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1803, 1'b1, 4'd3},
        '{1'b1, 32'h1102, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1901, 1'b0, 4'd5},
        '{1'b1, 32'h1000, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1901, 1'b0, 4'd5},
        '{1'b0, 32'h0,    1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 32'h1801, 1'b0, 4'd5},  // R5 no HS
        '{1'b1, 32'h1100, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1901, 1'b0, 4'd5},
        '{1'b1, 32'h1000, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1901, 1'b0, 4'd5},
        '{1'b0, 32'h0,    1'b1, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 32'h1805, 1'b0, 4'd5},
        '{1'b1, 32'h1000, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1801, 1'b0, 4'd4},  // R4 sw disable
        '{1'b1, 32'h31000,1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h31801,1'b0, 4'd13}, // R13 code 3
        '{1'b1, 32'h91000,1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h31801,1'b0, 4'd13}, // R13 reserved
        '{1'b1, 32'h1000, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1801, 1'b0, 4'd13},
        '{1'b0, 32'h0,    1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1401, 1'b0, 4'd10}, // R10 K line
        '{1'b0, 32'h0,    1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h3401, 1'b0, 4'd11}, // R11 handoff
        '{1'b0, 32'h0,    1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h3402, 1'b0, 4'd14}, // R14 owned
        '{1'b1, 32'h2000, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h2000, 1'b0, 4'd12}  // R12 power off
    };

    task automatic chk(input int req, input logic [31:0] exp, input logic exp_chg);
        n_run++;
        if (port_reg !== exp || chg_det !== exp_chg) begin
            n_fail++;
            $display("FAIL R%0d: port_reg=%h chg_det=%b expected port_reg=%h chg_det=%b",
                     req, port_reg, chg_det, exp, exp_chg);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b0;
        phy_jk  = 1'b0;
        ms_tick = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(1, 32'h0000_2000, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(1, 32'h0000_2000, 1'b0);

        // R2: configure flag rise hands port to this controller
        cfg_flag = 1'b1;
        step();
        chk(2, 32'h0000_0000, 1'b0);

        for (int i = 0; i < NROW; i++) begin
            wr_en    = TBL[i].wr;
            wr_data  = TBL[i].wd;
            phy_conn = TBL[i].conn;
            phy_line = TBL[i].line;
            oc_in    = TBL[i].oc;
            phy_jk   = TBL[i].jk;
            phy_hs   = TBL[i].hs;
            ms_tick  = TBL[i].tick;
            step();
            chk(int'(TBL[i].req), TBL[i].exp, TBL[i].chg);
        end

        // R2: written owner, then configure flag low and high again
        phy_conn = 1'b0;
        phy_line = 2'b00;
        wr_en = 1'b1; wr_data = 32'h1000;
        step();
        chk(2, 32'h1000, 1'b0);
        cfg_flag = 1'b0;
        step();
        chk(2, 32'h3000, 1'b0);
        cfg_flag = 1'b1;
        step();
        chk(2, 32'h1000, 1'b0);

        // R3: new connect change in the same clock as a clearing write
        step();
        phy_conn = 1'b1;
        wr_en = 1'b1; wr_data = 32'h1002;
        step();
        chk(3, 32'h1003, 1'b1);
        step();
        chk(14, 32'h1003, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule